// File: doc/BRIEF.md
# Self-routing Omega switching fabric

The block is a packet switching fabric with `PORTS` inputs and `PORTS` outputs (8 by default, any power of two). It is built from `log2(PORTS)` stages. Each stage is a perfect-shuffle wiring pattern followed by `PORTS/2` two-by-two switching elements. Every input presents, in each cycle, a valid flag, a destination outlet number and a payload word. No central controller exists. Each element looks at one bit of the destination of each packet that reaches it and steers that packet to its upper or lower output. The packet therefore reaches the outlet it names, provided it never has to share a link with another packet.

The network has exactly one path from any inlet to any outlet, so two packets may ask for the same internal link. When that happens, the packet arriving on the upper input of the element keeps the link and the other packet is dropped. The drop is reported on a per-input `blocked` flag, indexed by the input port that sent the packet. That flag appears in the same cycle as the outputs of the same wave, so a caller sees each packet either delivered or blocked. A parameter places a register after every stage. With the registers in, one new wave can enter every cycle, and each wave leaves `log2(PORTS)` cycles later.

Top module: `omega_fabric`

## Requirements
- R1: Right after reset is released, no output is valid and no `blocked` bit is set.
- R2: A packet that meets no other packet on its path leaves on the output whose index equals its destination. It carries its payload unchanged, and `out_src` on that output gives the number of the input it came from.
- R3: Stage h (1 to log2(PORTS)) first moves position i to position `(2*i mod PORTS) + (i >= PORTS/2 ? 1 : 0)`. It then routes by destination bit `log2(PORTS)-h`, so the most significant bit is used first: bit value 0 selects the even (upper) output of the element and bit value 1 the odd (lower) output. A set of packets whose paths share no link is delivered in full.
- R4: When the two inputs of one element ask for the same output, the packet on the even (upper) input wins. The packet on the odd input is dropped, and `blocked[s]` is set, where s is the input port that packet entered on.
- R5: Every valid input of a wave shows up exactly once: either as one valid output or as its own `blocked` bit, never both. Nothing else is reported.
- R6: With `PIPE`=1, a wave presented before clock edge E appears on the outputs after edge E+log2(PORTS)-1. A new wave may be presented on every cycle, and back-to-back waves do not affect one another.
- R7: An input whose valid flag is 0 produces no output and no `blocked` bit, whatever its destination and payload hold.
- R8: Whenever `out_valid[k]` is 1, `out_dest[k]` equals k.
- R9: An element that receives a single valid packet routes it by that packet's bit alone, whatever the other input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | PORTS | Per-input packet present flag |
| in_dest | input | PORTS x log2(PORTS) | Per-input destination outlet number |
| in_data | input | PORTS x DW | Per-input payload word |
| out_valid | output | PORTS | Per-output packet present flag |
| out_dest | output | PORTS x log2(PORTS) | Destination carried by the packet on each output |
| out_src | output | PORTS x log2(PORTS) | Input port the packet on each output came from |
| out_data | output | PORTS x DW | Payload on each output |
| blocked | output | PORTS | Per-input flag, set when that input's packet lost a link |

## Verification
The bench goes after the element decision and the shuffle wiring: every single-packet source and destination pair, every cyclic shift, and random permutations with conflicts. A wiring pattern that rotates the wrong way, or a stage that uses the wrong bit, would deliver packets to wrong outlets or would report false conflicts on conflict-free sets. Conflicting pairs check which input wins. A reversed priority would deliver the odd-input packet and flag the even one, and a stray index would set `blocked` on the wrong port. Waves that hold junk on invalid ports, sent back to back, expose any packet that is invented from an invalid input or that leaks into the next wave.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect shuffle on a BITS-wide position: rotate left by one.
  function automatic int unsigned shuffle_idx(input int unsigned idx,
                                              input int unsigned bits);
    int unsigned mask;
    mask = (1 << bits) - 1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_element.sv
// Two-by-two self-routing element: decision logic only, the stage muxes data.
module omega_element (
  input  logic [1:0] req_v,      // input j holds a packet
  input  logic [1:0] req_bit,    // routing bit of the packet on input j
  output logic [1:0] grant_v,    // output k carries a packet
  output logic [1:0] grant_from, // output k takes input 0 or input 1
  output logic       clash       // input 1 lost its requested output
);
  always_comb begin
    clash = req_v[0] & req_v[1] & (req_bit[0] == req_bit[1]);
    for (int k = 0; k < 2; k++) begin
      if (req_v[0] && (req_bit[0] == 1'(k))) begin
        grant_v[k]    = 1'b1;
        grant_from[k] = 1'b0;
      end else if (req_v[1] && (req_bit[1] == 1'(k))) begin
        grant_v[k]    = 1'b1;
        grant_from[k] = 1'b1;
      end else begin
        grant_v[k]    = 1'b0;
        grant_from[k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/omega_stage.sv
// One fabric stage: shuffle wiring, a column of elements, optional register.
module omega_stage #(
  parameter int PORTS = 8,
  parameter int AW    = $clog2(PORTS),
  parameter int DW    = 16,
  parameter int STAGE = 1,
  parameter bit PIPE  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PORTS-1:0]          i_v,
  input  logic [PORTS-1:0][AW-1:0]  i_dst,
  input  logic [PORTS-1:0][AW-1:0]  i_src,
  input  logic [PORTS-1:0][DW-1:0]  i_dat,
  input  logic [PORTS-1:0]          i_blk,
  output logic [PORTS-1:0]          o_v,
  output logic [PORTS-1:0][AW-1:0]  o_dst,
  output logic [PORTS-1:0][AW-1:0]  o_src,
  output logic [PORTS-1:0][DW-1:0]  o_dat,
  output logic [PORTS-1:0]          o_blk,
  output logic [PORTS/2-1:0]        o_clash
);
  localparam int HALF = PORTS / 2;
  localparam int BIT  = AW - STAGE;

  logic [PORTS-1:0]         sh_v;
  logic [PORTS-1:0][AW-1:0] sh_dst, sh_src;
  logic [PORTS-1:0][DW-1:0] sh_dat;

  logic [PORTS-1:0]         nx_v;
  logic [PORTS-1:0][AW-1:0] nx_dst, nx_src;
  logic [PORTS-1:0][DW-1:0] nx_dat;
  logic [PORTS-1:0]         nx_blk;

  logic [HALF-1:0][1:0] gv, gf;
  logic [HALF-1:0]      clash;

  // Perfect shuffle in front of the element column.
  for (genvar j = 0; j < PORTS; j++) begin : g_shuf
    localparam int unsigned TO = omega_pkg::shuffle_idx(j, AW);
    assign sh_v[TO]   = i_v[j];
    assign sh_dst[TO] = i_dst[j];
    assign sh_src[TO] = i_src[j];
    assign sh_dat[TO] = i_dat[j];
  end

  for (genvar e = 0; e < HALF; e++) begin : g_elem
    omega_element u_elem (
      .req_v     ({sh_v[2*e+1], sh_v[2*e]}),
      .req_bit   ({sh_dst[2*e+1][BIT], sh_dst[2*e][BIT]}),
      .grant_v   (gv[e]),
      .grant_from(gf[e]),
      .clash     (clash[e])
    );
    for (genvar k = 0; k < 2; k++) begin : g_out
      assign nx_v[2*e+k]   = gv[e][k];
      assign nx_dst[2*e+k] = gf[e][k] ? sh_dst[2*e+1] : sh_dst[2*e];
      assign nx_src[2*e+k] = gf[e][k] ? sh_src[2*e+1] : sh_src[2*e];
      assign nx_dat[2*e+k] = gf[e][k] ? sh_dat[2*e+1] : sh_dat[2*e];
    end
  end

  // A loser is always the odd-input packet; flag the port it entered on.
  always_comb begin
    nx_blk = i_blk;
    for (int e = 0; e < HALF; e++) begin
      if (clash[e]) nx_blk[sh_src[2*e+1]] = 1'b1;
    end
  end

  assign o_clash = clash;

  if (PIPE) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        o_v   <= '0;
        o_blk <= '0;
        o_dst <= '0;
        o_src <= '0;
        o_dat <= '0;
      end else begin
        o_v   <= nx_v;
        o_blk <= nx_blk;
        o_dst <= nx_dst;
        o_src <= nx_src;
        o_dat <= nx_dat;
      end
    end
  end else begin : g_comb
    assign o_v   = nx_v;
    assign o_blk = nx_blk;
    assign o_dst = nx_dst;
    assign o_src = nx_src;
    assign o_dat = nx_dat;
  end
endmodule

// File: rtl/omega_fabric.sv
// Self-routing Omega fabric: log2(PORTS) shuffle-and-switch stages.
module omega_fabric #(
  parameter int PORTS = 8,
  parameter int DW    = 16,
  parameter bit PIPE  = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [PORTS-1:0]                    in_valid,
  input  logic [PORTS-1:0][$clog2(PORTS)-1:0] in_dest,
  input  logic [PORTS-1:0][DW-1:0]            in_data,
  output logic [PORTS-1:0]                    out_valid,
  output logic [PORTS-1:0][$clog2(PORTS)-1:0] out_dest,
  output logic [PORTS-1:0][$clog2(PORTS)-1:0] out_src,
  output logic [PORTS-1:0][DW-1:0]            out_data,
  output logic [PORTS-1:0]                    blocked
);
  localparam int AW   = $clog2(PORTS);
  localparam int HALF = PORTS / 2;

  logic [AW:0][PORTS-1:0]         st_v;
  logic [AW:0][PORTS-1:0][AW-1:0] st_dst, st_src;
  logic [AW:0][PORTS-1:0][DW-1:0] st_dat;
  logic [AW:0][PORTS-1:0]         st_blk;

  // Per-stage conflict events, brought out for the checker.
  logic [AW-1:0][HALF-1:0]        stage_clash;

  assign st_v[0]   = in_valid;
  assign st_dst[0] = in_dest;
  assign st_dat[0] = in_data;
  assign st_blk[0] = '0;
  for (genvar k = 0; k < PORTS; k++) begin : g_tag
    assign st_src[0][k] = AW'(k);
  end

  for (genvar h = 1; h <= AW; h++) begin : g_stage
    omega_stage #(
      .PORTS(PORTS), .AW(AW), .DW(DW), .STAGE(h), .PIPE(PIPE)
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .i_v    (st_v[h-1]),
      .i_dst  (st_dst[h-1]),
      .i_src  (st_src[h-1]),
      .i_dat  (st_dat[h-1]),
      .i_blk  (st_blk[h-1]),
      .o_v    (st_v[h]),
      .o_dst  (st_dst[h]),
      .o_src  (st_src[h]),
      .o_dat  (st_dat[h]),
      .o_blk  (st_blk[h]),
      .o_clash(stage_clash[h-1])
    );
  end

  assign out_valid = st_v[AW];
  assign out_dest  = st_dst[AW];
  assign out_src   = st_src[AW];
  assign out_data  = st_dat[AW];
  assign blocked   = st_blk[AW];
endmodule

// File: rtl/omega_fabric_chk.sv
module omega_fabric_chk #(
  parameter int PORTS = 8,
  parameter int AW    = 3,
  parameter bit PIPE  = 1'b1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [PORTS-1:0]          in_valid,
  input logic [PORTS-1:0]          out_valid,
  input logic [PORTS-1:0][AW-1:0]  out_dest,
  input logic [PORTS-1:0][AW-1:0]  out_src,
  input logic [PORTS-1:0]          blocked
);
  int unsigned exp_cnt;

  if (PIPE) begin : g_delay
    int unsigned cnt_q [AW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < AW; i++) cnt_q[i] <= 0;
      end else begin
        cnt_q[0] <= $countones(in_valid);
        for (int i = 1; i < AW; i++) cnt_q[i] <= cnt_q[i-1];
      end
    end
    assign exp_cnt = cnt_q[AW-1];

    // R1: outputs quiet on the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_valid == '0 && blocked == '0));
  end else begin : g_nodelay
    assign exp_cnt = $countones(in_valid);
  end

  // R5: every packet of a wave is delivered or blocked, nothing more
  p_conserve_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_valid) + $countones(blocked)) == exp_cnt);

  // R4: a blocked packet needs at least one rival in its wave
  p_block_needs_rival_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked != '0) |-> (exp_cnt >= 2));

  for (genvar k = 0; k < PORTS; k++) begin : g_port
    // R8: an output only carries packets addressed to it
    p_dest_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[k] |-> (out_dest[k] == AW'(k)));
    // R5: a delivered packet is never also flagged blocked
    p_not_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[k] |-> !blocked[out_src[k]]);
  end
endmodule

bind omega_fabric omega_fabric_chk #(.PORTS(PORTS), .AW(AW), .PIPE(PIPE)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_dest (out_dest),
  .out_src  (out_src),
  .blocked  (blocked)
);

// File: tb/omega_fabric_tb_top.sv
module omega_fabric_tb_top;
  localparam int P   = 8;
  localparam int AW  = 3;
  localparam int DW  = 16;
  localparam int LAT = AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0]          in_valid = '0;
  logic [P-1:0][AW-1:0]  in_dest  = '0;
  logic [P-1:0][DW-1:0]  in_data  = '0;
  logic [P-1:0]          out_valid;
  logic [P-1:0][AW-1:0]  out_dest;
  logic [P-1:0][AW-1:0]  out_src;
  logic [P-1:0][DW-1:0]  out_data;
  logic [P-1:0]          blocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  omega_fabric #(.PORTS(P), .DW(DW), .PIPE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_dest(out_dest),
    .out_src(out_src), .out_data(out_data), .blocked(blocked)
  );

  typedef struct {
    logic [P-1:0]         v;
    logic [P-1:0][DW-1:0] dat;
    logic [P-1:0][AW-1:0] src;
    logic [P-1:0]         blk;
    string                tag;
  } exp_t;

  exp_t sb[$];

  // Reference: track each packet's position through the stages.
  function automatic exp_t model(input logic [P-1:0] v,
                                 input logic [P-1:0][AW-1:0] d,
                                 input logic [P-1:0][DW-1:0] dat,
                                 input string tag);
    exp_t e;
    int pos [P];
    bit live [P];
    e.v = '0; e.dat = '0; e.src = '0; e.blk = '0; e.tag = tag;
    for (int s = 0; s < P; s++) begin pos[s] = s; live[s] = v[s]; end
    for (int h = 1; h <= AW; h++) begin
      for (int s = 0; s < P; s++)
        pos[s] = ((pos[s] * 2) % P) + ((pos[s] >= P/2) ? 1 : 0);
      for (int el = 0; el < P/2; el++) begin
        int up = -1;
        int lo = -1;
        for (int s = 0; s < P; s++) begin
          if (live[s] && pos[s] == 2*el)     up = s;
          if (live[s] && pos[s] == 2*el + 1) lo = s;
        end
        if (up >= 0 && lo >= 0 && d[up][AW-h] == d[lo][AW-h]) begin
          live[lo] = 0;
          e.blk[lo] = 1'b1;
        end
        if (up >= 0) pos[up] = 2*el + int'(d[up][AW-h]);
        if (lo >= 0 && live[lo]) pos[lo] = 2*el + int'(d[lo][AW-h]);
      end
    end
    for (int s = 0; s < P; s++) begin
      if (live[s]) begin
        e.v[pos[s]]   = 1'b1;
        e.dat[pos[s]] = dat[s];
        e.src[pos[s]] = AW'(s);
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [P-1:0] v,
                       input logic [P-1:0][AW-1:0] d,
                       input logic [P-1:0][DW-1:0] dat,
                       input string tag);
    @(negedge clk);
    #1;
    in_valid = v;
    in_dest  = d;
    in_data  = dat;
    sb.push_back(model(v, d, dat, tag));
  endtask

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Monitor: one wave leaves LAT negedges after it was driven.
  always @(negedge clk) begin
    if (rst_n && sb.size() == LAT) begin
      exp_t e;
      e = sb.pop_front();
      check(out_valid == e.v, {e.tag, " out_valid"}, 64'(out_valid), 64'(e.v));
      check(blocked == e.blk, {e.tag, " R4 blocked"}, 64'(blocked), 64'(e.blk));
      for (int k = 0; k < P; k++) begin
        if (e.v[k] && out_valid[k]) begin
          check(out_data[k] == e.dat[k], {e.tag, " R2 payload"},
                64'(out_data[k]), 64'(e.dat[k]));
          check(out_src[k] == e.src[k], {e.tag, " R2 source"},
                64'(out_src[k]), 64'(e.src[k]));
          check(out_dest[k] == AW'(k), {e.tag, " R8 dest"},
                64'(out_dest[k]), 64'(k));
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [P-1:0]         v;
    logic [P-1:0][AW-1:0] d;
    logic [P-1:0][DW-1:0] dat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(out_valid == '0, "R1 out_valid after reset", 64'(out_valid), 0);
    check(blocked == '0, "R1 blocked after reset", 64'(blocked), 0);

    // R2, R9: every single source to every destination, garbage elsewhere
    for (int s = 0; s < P; s++) begin
      for (int t = 0; t < P; t++) begin
        v = '0; v[s] = 1'b1;
        for (int k = 0; k < P; k++) begin
          d[k] = AW'($urandom);
          dat[k] = DW'($urandom);
        end
        d[s] = AW'(t);
        drive(v, d, dat, "R2/R9 single");
      end
    end

    // R3: cyclic shifts, full waves
    for (int c = 0; c < P; c++) begin
      v = '1;
      for (int k = 0; k < P; k++) begin
        d[k] = AW'((k + c) % P);
        dat[k] = DW'(16'h1000 * c + k);
      end
      drive(v, d, dat, "R3 shift");
    end

    // R4: inputs 0 and 4 meet in element 0 of stage 1 and share the MSB
    v = '0; v[0] = 1'b1; v[4] = 1'b1;
    d = '0; d[0] = 3'd1; d[4] = 3'd2;
    dat = '0; dat[0] = 16'hAAAA; dat[4] = 16'h5555;
    drive(v, d, dat, "R4 pair");
    // Same pair, differing MSB: both delivered
    d[4] = 3'd6;
    drive(v, d, dat, "R4 no-clash pair");

    // R5, R6: random permutations back to back
    for (int w = 0; w < 200; w++) begin
      int perm [P];
      for (int k = 0; k < P; k++) perm[k] = k;
      for (int k = P - 1; k > 0; k--) begin
        int j;
        int tmp;
        j = $urandom_range(k, 0);
        tmp = perm[k]; perm[k] = perm[j]; perm[j] = tmp;
      end
      v = '1;
      for (int k = 0; k < P; k++) begin
        d[k] = AW'(perm[k]);
        dat[k] = DW'($urandom);
      end
      drive(v, d, dat, "R5/R6 perm");
    end

    // R7: random subsets, junk on invalid ports, repeated destinations
    for (int w = 0; w < 200; w++) begin
      v = P'($urandom);
      for (int k = 0; k < P; k++) begin
        d[k] = AW'($urandom);
        dat[k] = DW'($urandom);
      end
      drive(v, d, dat, "R7 subset");
    end

    // flush
    for (int w = 0; w < LAT + 1; w++) drive('0, '0, '0, "R7 idle");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule